// File: doc/BRIEF.md
# Serial-Link Operand Adder Display

This block joins a sender and a receiver that share one clock and one data wire. A start strobe loads an 8-bit switch value into the sender's shift register. The sender then puts that word on the wire one bit per clock, most significant bit first, and the receiver shifts the same bits in.

A plain receiver shift register would keep shifting after the word has arrived and would end up full of zeros. This receiver counts the bits instead. When the eighth bit comes in, it copies the frame into a hold register, raises a valid flag and stops shifting. The held word stays put however long the clock keeps running.

Two 3-bit unsigned operands are taken from the held word and added. The sum is split into a tens digit and a units digit, and each digit drives a 7-segment pattern.

Top module: `serlink_adder_top`

## Requirements
- R1: While rst_ni is low, and right after it is released, word_o, valid_o, line_o and sum_o are 0. seg_units_o shows the digit 0 (7'h3F) and seg_tens_o is blank (7'h00).
- R2: The clock edge that samples start_i high loads sw_i into the sender. line_o then carries sw_i[7] until the next edge. One edge later it carries sw_i[6], and so on down to sw_i[0].
- R3: On the eighth clock edge after the start edge, valid_o goes to 1 and word_o becomes equal to the loaded sw_i.
- R4: Once valid_o is 1, word_o and valid_o stay unchanged on every edge until start_i is sampled high again. Continued clocking does not flush the held word.
- R5: sum_o equals word_o[2:0] + word_o[5:3], an unsigned value from 0 to 14. Bits word_o[7:6] have no effect on the sum.
- R6: seg_units_o shows sum_o mod 10 as an active-high pattern. Bit 0 is segment a and bit 6 is segment g. The codes for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hex.
- R7: seg_tens_o is 7'h00 (blank) when sum_o is below 10. From 10 upward it shows the digit 1 (7'h06).
- R8: valid_o is 0 from the start edge until the frame completes. During that time word_o keeps the previously held word.
- R9: If start_i is sampled high while a frame is in transfer, the transfer restarts with the new sw_i. The earlier frame never sets valid_o, and the new word appears on the eighth edge after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock for sender and receiver |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_i | input | 8 | Switch word loaded into the sender |
| start_i | input | 1 | Load and start strobe |
| line_o | output | 1 | Serial data wire, MSB first |
| word_o | output | 8 | Held received word |
| valid_o | output | 1 | Held word holds a complete frame |
| sum_o | output | 4 | Sum of the two 3-bit operands |
| seg_tens_o | output | 7 | Tens digit segments, gfedcba, active high |
| seg_units_o | output | 7 | Units digit segments, gfedcba, active high |

## Verification
A bit counter that is off by one shows up in the same cycle that valid_o rises. word_o then differs from sw_i by a one-place shift, and valid_o rises one cycle early or late. A hold register that keeps loading shows up within one clock as a change on word_o while valid_o is high and no start has occurred. A wrong operand slice or a wrong BCD split is visible at once on sum_o and on the segment ports as soon as the word is held. The stimulus therefore includes sums of 9 and 10 and words with bits 7:6 set.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned OPND_W = 3;
  localparam int unsigned SEG_W  = 7;

  // active-high, bit0 = a .. bit6 = g
  function automatic logic [SEG_W-1:0] seg7(input logic [3:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/serlink_tx.sv
module serlink_tx #(
  parameter int unsigned W = serlink_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         line_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= data_i;
    else if (shift_i) q <= {q[W-2:0], 1'b0};
  end

  assign line_o = q[W-1];
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx #(
  parameter int unsigned W = serlink_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         bit_i,
  output logic         busy_o,
  output logic         valid_o,
  output logic [W-1:0] hold_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-2:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, valid_q;
  logic [W-1:0]     hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      hold_q  <= '0;
    end else if (start_i) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
    end else if (busy_q) begin
      sr_q  <= {sr_q[W-3:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        // last bit comes straight from the wire; freeze afterwards
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        hold_q  <= {sr_q, bit_i};
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign hold_o  = hold_q;

  AST_FRAME_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST && !start_i) |=> (valid_q && !busy_q)); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !start_i) |=> ($stable(hold_q) && valid_q)); // R4
  AST_NO_VALID_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !valid_q); // R8
endmodule

// File: rtl/serlink_bcd_seg.sv
module serlink_bcd_seg #(
  parameter int unsigned SUM_W = serlink_pkg::OPND_W + 1,
  parameter int unsigned SEG_W = serlink_pkg::SEG_W
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [SEG_W-1:0] tens_seg_o,
  output logic [SEG_W-1:0] units_seg_o
);
  logic [SUM_W-1:0] tens_v, units_v;

  always_comb begin
    tens_v      = sum_i / SUM_W'(10);
    units_v     = sum_i % SUM_W'(10);
    units_seg_o = serlink_pkg::seg7(4'(units_v));
    tens_seg_o  = (tens_v == '0) ? '0 : serlink_pkg::seg7(4'(tens_v));
  end
endmodule

// File: rtl/serlink_adder_top.sv
module serlink_adder_top #(
  parameter int unsigned WORD_W = serlink_pkg::WORD_W,
  parameter int unsigned OPND_W = serlink_pkg::OPND_W,
  parameter int unsigned SEG_W  = serlink_pkg::SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] sw_i,
  input  logic              start_i,
  output logic              line_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [OPND_W:0]   sum_o,
  output logic [SEG_W-1:0]  seg_tens_o,
  output logic [SEG_W-1:0]  seg_units_o
);
  localparam int unsigned SUM_W = OPND_W + 1;
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(2 * ((1 << OPND_W) - 1));

  logic busy, rx_bit;

  serlink_tx #(.W(WORD_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .shift_i(busy),
    .data_i (sw_i),
    .line_o (line_o)
  );

  // receiver input gate with its second leg tied high
  assign rx_bit = line_o & 1'b1;

  serlink_rx #(.W(WORD_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .bit_i  (rx_bit),
    .busy_o (busy),
    .valid_o(valid_o),
    .hold_o (word_o)
  );

  assign sum_o = {1'b0, word_o[OPND_W-1:0]} + {1'b0, word_o[2*OPND_W-1:OPND_W]};

  serlink_bcd_seg #(.SUM_W(SUM_W), .SEG_W(SEG_W)) u_seg (
    .sum_i      (sum_o),
    .tens_seg_o (seg_tens_o),
    .units_seg_o(seg_units_o)
  );

  AST_SUM_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= SUM_MAX); // R5
  AST_TENS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_o < SUM_W'(10)) |-> (seg_tens_o == '0)); // R7
  AST_LINE_HOLDS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (line_o == $past(sw_i[WORD_W-1]))); // R2
endmodule

// File: tb/tb_serlink_adder_top.sv
module tb_serlink_adder_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sw_i = '0;
  logic       start_i = 1'b0;
  logic       line_o, valid_o;
  logic [7:0] word_o;
  logic [3:0] sum_o;
  logic [6:0] seg_tens_o, seg_units_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  serlink_adder_top dut (.*);

  // {switch word, expected sum}
  localparam logic [11:0] VEC [9] = '{
    {8'h00, 4'd0}, {8'h11, 4'd3}, {8'h3F, 4'd14}, {8'hC0, 4'd0},
    {8'hFF, 4'd14}, {8'h33, 4'd9}, {8'h2D, 4'd10}, {8'h1A, 4'd5},
    {8'h4E, 4'd7}
  };

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] w);
    logic [7:0] prev;
    prev = word_o;
    sw_i = w; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(line_o == w[7-k], "R2 line bit", 32'(line_o), 32'(w[7-k]));
      check(valid_o == 1'b0, "R8 valid low in flight", 32'(valid_o), 0);
      check(word_o == prev, "R8 old word kept", 32'(word_o), 32'(prev));
      @(negedge clk_i);
    end
    check(valid_o == 1'b1, "R3 valid after 8", 32'(valid_o), 1);
    check(word_o == w, "R3 word", 32'(word_o), 32'(w));
  endtask

  task automatic check_sum(input logic [3:0] es);
    check(sum_o == es, "R5 sum", 32'(sum_o), 32'(es));
    check(seg_units_o == exp_seg(int'(es) % 10), "R6 units seg",
          32'(seg_units_o), 32'(exp_seg(int'(es) % 10)));
    check(seg_tens_o == ((es >= 10) ? 7'h06 : 7'h00), "R7 tens seg",
          32'(seg_tens_o), (es >= 10) ? 32'h06 : 32'h00);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: in reset
    check(word_o == 0 && valid_o == 0 && line_o == 0 && sum_o == 0, "R1 reset outputs",
          {word_o, 3'b0, valid_o, 3'b0, line_o, 4'b0, sum_o}, 0);
    check(seg_units_o == 7'h3F && seg_tens_o == 7'h00, "R1 reset segs",
          {seg_tens_o, seg_units_o}, {7'h00, 7'h3F});
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(word_o == 0 && valid_o == 0, "R1 after release", {word_o, 7'b0, valid_o}, 0);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 9; i++) begin
      run_frame(VEC[i][11:4]);
      check_sum(VEC[i][3:0]);
    end

    // R4: hold under continued clocking, with switches changing
    sw_i = 8'h00;
    repeat (20) @(negedge clk_i);
    check(word_o == 8'h4E && valid_o == 1'b1, "R4 hold frozen",
          {word_o, 7'b0, valid_o}, {8'h4E, 8'h01});
    check_sum(4'd7);

    // R5: bits 7:6 ignored (A=3,B=6 with top bits set)
    run_frame(8'hF3);
    check_sum(4'd9);

    // R9: restart mid-frame
    sw_i = 8'h2D; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    sw_i = 8'h11; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(line_o == 1'b0, "R9 new MSB on line", 32'(line_o), 0);
    repeat (5) @(negedge clk_i);
    check(valid_o == 1'b0, "R9 first frame dropped", 32'(valid_o), 0);
    check(word_o == 8'hF3, "R9 old word kept", 32'(word_o), 32'hF3);
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b1 && word_o == 8'h11, "R9 restarted word",
          {word_o, 7'b0, valid_o}, {8'h11, 8'h01});
    check_sum(4'd3);

    // R1: asynchronous reset mid-frame
    sw_i = 8'hFF; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check(word_o == 0 && valid_o == 0 && line_o == 0, "R1 async reset",
          {word_o, 3'b0, valid_o, 3'b0, line_o}, 0);
    check(seg_units_o == 7'h3F && seg_tens_o == 7'h00, "R1 segs after reset",
          {seg_tens_o, seg_units_o}, {7'h00, 7'h3F});
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_frame(8'h3F);
    check_sum(4'd14);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule